// File: doc/BRIEF.md
# Phase Tracking Servo Controller

This block centres a phase control value against an external phase comparator. After a start pulse it closes bus access to the clocked unit, switches the unit from hardware phase alignment to software alignment, and then moves the phase control by a single step at a time. The direction of each step comes from a multi-bit status code. Codes above the centre code move the phase up and codes below it move the phase down. Reaching the centre code ends the run. Bus access then reopens, and the number of steps taken is shown on the count output.

Each step changes the phase output and toggles the load strobe in the same cycle. A settle timer then runs so that the comparator has time to respond before the next status sample. The phase value wraps at both ends of its range. If the step budget runs out before the centre code is seen, the block raises fail and keeps bus access closed. A new run starts only from idle, and each run begins from the phase value left by the previous run.

There is no streaming data path. Every pin is a plain control or status signal, so the block needs no valid/ready handshake and has no back-pressure rules.

Top module: `phase_servo_ctrl`

## Requirements
- R1: After reset the outputs are: phase_o = PH_RESET (default 32), load_o = 0, bus_en_o = 1, hw_align_o = 1, sw_align_o = 0, done_o = 0, fail_o = 0, count_o = 0.
- R2: When idle, a start_i seen at a rising edge gives bus_en_o = 0, hw_align_o = 0, sw_align_o = 1, done_o = 0, fail_o = 0 and count_o = 0 from the next cycle on. bus_en_o stays 0 for as long as the run lasts.
- R3: status_i is sampled only at the rising edge that comes SETTLE_CYC+1 edges after the start edge or after the last step edge. Its value at any other edge has no effect.
- R4: At a sample, a status above CENTER (15) raises phase_o by 1, and a status below 15 lowers phase_o by 1.
- R5: Every step toggles load_o in the same cycle that phase_o changes, and raises count_o by 1.
- R6: A sample equal to 15 ends the run. done_o = 1 and bus_en_o = 1, and count_o holds the number of steps made in that run (0 if the first sample is already 15).
- R7: Once count_o equals MAX_ADJ, the next sample ends the run with fail_o = 1, whatever the status is. bus_en_o stays 0, and phase_o makes no further change.
- R8: phase_o is PH_W bits wide (6). A step up from 63 gives 0, and a step down from 0 gives 63.
- R9: A start_i pulse that arrives while a run is in progress has no effect.
- R10: hw_align_o and sw_align_o are never both 1. After the first start they stay at 0 and 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| status_i | input | ST_W (5) | Phase comparator status code |
| phase_o | output | PH_W (6) | Phase control value |
| load_o | output | 1 | Load strobe, toggles on every step |
| bus_en_o | output | 1 | Bus access enable for the clocked unit |
| hw_align_o | output | 1 | Hardware alignment select |
| sw_align_o | output | 1 | Software alignment select |
| done_o | output | 1 | Last run reached the centre code |
| fail_o | output | 1 | Last run used up the step budget |
| count_o | output | CNT_W (16) | Steps made in the current or last run |

## Verification
A settle timer that is off by one cycle moves the sampling edge. When the status changes while the timer is running, the phase then moves in the wrong direction or the run ends early, and the per-cycle comparison catches it within one settle window. A wrong step direction or a missing wrap shows on phase_o at the very edge where the step happens. A fault in the step counter or the budget comparison shows up as a wrong count_o at once, or as a fail_o that rises one sample too early or too late. A bus enable that reopens by mistake appears in the cycle after the faulty transition.

// File: rtl/phase_servo_pkg.sv
package phase_servo_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_WAIT = 1'b1
  } ps_state_e;

  typedef enum logic [1:0] {
    V_UP   = 2'd0,
    V_DOWN = 2'd1,
    V_HIT  = 2'd2
  } verdict_e;
endpackage

// File: rtl/phase_servo_timer.sv
module phase_servo_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= TW'(SETTLE_CYC);
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/phase_servo_judge.sv
module phase_servo_judge
  import phase_servo_pkg::*;
#(
  parameter int ST_W   = 5,
  parameter int CENTER = 15
) (
  input  logic [ST_W-1:0] status_i,
  output verdict_e        verdict_o
);
  localparam logic [ST_W-1:0] CODE_MID = ST_W'(CENTER);

  always_comb begin
    if (status_i > CODE_MID)      verdict_o = V_UP;
    else if (status_i < CODE_MID) verdict_o = V_DOWN;
    else                          verdict_o = V_HIT;
  end
endmodule

// File: rtl/phase_servo_stepper.sv
module phase_servo_stepper #(
  parameter int PH_W     = 6,
  parameter int CNT_W    = 16,
  parameter int PH_RESET = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             up_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             load_o,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_W'(PH_RESET);
      load_o  <= 1'b0;
      count_o <= '0;
    end else if (clear_i) begin
      count_o <= '0;
    end else if (step_i) begin
      phase_o <= up_i ? phase_o + 1'b1 : phase_o - 1'b1;
      load_o  <= ~load_o;
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/phase_servo_ctrl.sv
module phase_servo_ctrl
  import phase_servo_pkg::*;
#(
  parameter int PH_W       = 6,
  parameter int ST_W       = 5,
  parameter int CENTER     = 15,
  parameter int CNT_W      = 16,
  parameter int MAX_ADJ    = 65535,
  parameter int SETTLE_CYC = 3,
  parameter int PH_RESET   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ST_W-1:0]  status_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             load_o,
  output logic             bus_en_o,
  output logic             hw_align_o,
  output logic             sw_align_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] BUDGET = CNT_W'(MAX_ADJ);

  ps_state_e state_q;
  verdict_e  verdict;
  logic      busy;
  logic      launch;
  logic      expired;
  logic      at_limit;
  logic      sample;
  logic      step;
  logic      finish_ok;
  logic      finish_bad;

  assign busy       = (state_q == PS_WAIT);
  assign launch     = !busy && start_i;
  assign at_limit   = (count_o == BUDGET);
  assign sample     = busy && expired;
  assign step       = sample && !at_limit && (verdict != V_HIT);
  assign finish_ok  = sample && !at_limit && (verdict == V_HIT);
  assign finish_bad = sample && at_limit;

  phase_servo_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (launch || step),
    .run_i     (busy),
    .expired_o (expired)
  );

  phase_servo_judge #(.ST_W(ST_W), .CENTER(CENTER)) u_judge (
    .status_i  (status_i),
    .verdict_o (verdict)
  );

  phase_servo_stepper #(.PH_W(PH_W), .CNT_W(CNT_W), .PH_RESET(PH_RESET)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (launch),
    .step_i  (step),
    .up_i    (verdict == V_UP),
    .phase_o (phase_o),
    .load_o  (load_o),
    .count_o (count_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
    end else if (launch) begin
      state_q <= PS_WAIT;
    end else if (finish_ok || finish_bad) begin
      state_q <= PS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_en_o   <= 1'b1;
      hw_align_o <= 1'b1;
      sw_align_o <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else if (launch) begin
      bus_en_o   <= 1'b0;
      hw_align_o <= 1'b0;
      sw_align_o <= 1'b1;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else if (finish_ok) begin
      bus_en_o <= 1'b1;
      done_o   <= 1'b1;
    end else if (finish_bad) begin
      fail_o <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_servo_chk.sv
module phase_servo_chk #(
  parameter int PH_W  = 6,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [PH_W-1:0]  phase_o,
  input logic             load_o,
  input logic             bus_en_o,
  input logic             hw_align_o,
  input logic             sw_align_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] count_o
);
  a_r10_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_align_o && sw_align_o));

  a_r2_closed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!bus_en_o && !done_o && !fail_o));

  a_r6_done_opens_access: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bus_en_o && !fail_o));

  a_r7_fail_keeps_closed: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> !bus_en_o);

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |->
      ((phase_o == PH_W'($past(phase_o) + 1'b1)) || (phase_o == PH_W'($past(phase_o) - 1'b1))));

  a_r5_strobe_with_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> (load_o != $past(load_o)));

  a_r5_count_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o != $past(load_o)) |-> (count_o == CNT_W'($past(count_o) + 1'b1)));
endmodule

bind phase_servo_ctrl phase_servo_chk #(.PH_W(PH_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .phase_o    (phase_o),
  .load_o     (load_o),
  .bus_en_o   (bus_en_o),
  .hw_align_o (hw_align_o),
  .sw_align_o (sw_align_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .count_o    (count_o)
);

// File: tb/phase_servo_ctrl_tb.sv
`timescale 1ns/1ps
module phase_servo_ctrl_tb;
  localparam int S    = 3;
  localparam int MAXA = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  status;
  logic [5:0]  phase;
  logic        load, bus_en, hw, sw, done, fail;
  logic [15:0] count;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;     // 0 track target, 1 stuck at 0, 2 pattern, 3 hold 15
  int target = 32;
  int pat    = 0;

  always #10 clk = ~clk;

  phase_servo_ctrl #(.MAX_ADJ(MAXA), .SETTLE_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .status_i(status),
    .phase_o(phase), .load_o(load), .bus_en_o(bus_en), .hw_align_o(hw),
    .sw_align_o(sw), .done_o(done), .fail_o(fail), .count_o(count)
  );

  always_comb begin
    int d;
    int s;
    d = (target - int'(phase) + 64) % 64;
    if (d >= 32) d = d - 64;
    s = 15 + d;
    if (s < 0) s = 0;
    if (s > 31) s = 31;
    case (mode)
      1:       status = 5'd0;
      2:       status = 5'(pat);
      3:       status = 5'd15;
      default: status = 5'(s);
    endcase
  end

  // behavioural reference
  int m_phase, m_cnt, m_wait;
  bit m_busy, m_load, m_bus, m_hw, m_sw, m_done, m_fail;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 32; m_cnt = 0; m_wait = 0; m_busy = 0; m_load = 0;
      m_bus = 1; m_hw = 1; m_sw = 0; m_done = 0; m_fail = 0;
    end else if (!m_busy) begin
      if (start) begin
        m_busy = 1; m_wait = S; m_cnt = 0; m_bus = 0; m_hw = 0; m_sw = 1;
        m_done = 0; m_fail = 0;
      end
    end else if (m_wait > 0) begin
      m_wait = m_wait - 1;
    end else if (m_cnt == MAXA) begin
      m_fail = 1; m_busy = 0;
    end else if (status == 5'd15) begin
      m_done = 1; m_bus = 1; m_busy = 0;
    end else begin
      m_phase = (m_phase + ((status > 5'd15) ? 1 : 63)) % 64;
      m_load = !m_load; m_cnt = m_cnt + 1; m_wait = S;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4/R8 phase vs model", int'(phase), m_phase);
      chk("R5 load vs model", int'(load), int'(m_load));
      chk("R5 count vs model", int'(count), m_cnt);
      chk("R2/R6 bus_en vs model", int'(bus_en), int'(m_bus));
      chk("R10 hw select vs model", int'(hw), int'(m_hw));
      chk("R10 sw select vs model", int'(sw), int'(m_sw));
      chk("R6 done vs model", int'(done), int'(m_done));
      chk("R7 fail vs model", int'(fail), int'(m_fail));
    end
    pat = (pat + 7) % 32;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_to_end();
    pulse_start();
    for (int i = 0; i < 3000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 phase", int'(phase), 32);
    chk("R1 load", int'(load), 0);
    chk("R1 bus_en", int'(bus_en), 1);
    chk("R1 hw", int'(hw), 1);
    chk("R1 sw", int'(sw), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 count", int'(count), 0);
    rst_n = 1'b1;

    // R2: outputs right after start, R4 upward to 40
    mode = 0; target = 40;
    pulse_start();
    chk("R2 bus_en closed", int'(bus_en), 0);
    chk("R10 hw off", int'(hw), 0);
    chk("R10 sw on", int'(sw), 1);
    for (int i = 0; i < 3000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    chk("R6 done up", int'(done), 1);
    chk("R6 bus reopened", int'(bus_en), 1);
    chk("R6 count up", int'(count), 8);
    chk("R4 phase up", int'(phase), 40);

    // R4 downward to 36
    target = 36; run_to_end();
    chk("R4 phase down", int'(phase), 36);
    chk("R6 count down", int'(count), 4);

    // R6 already centred
    run_to_end();
    chk("R6 zero steps done", int'(done), 1);
    chk("R6 zero steps count", int'(count), 0);

    // R3: status is 15 during the wait, ignored; tracking at sample
    target = 30; mode = 3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mode = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    chk("R3 wait-time status ignored count", int'(count), 6);
    chk("R3 phase", int'(phase), 30);

    // R9: start during run ignored
    target = 33;
    pulse_start();
    repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
    chk("R9 count unaffected", int'(count), 3);
    chk("R9 phase", int'(phase), 33);

    // R8 wrap up and down
    target = 60; run_to_end();
    chk("R8 setup phase", int'(phase), 60);
    target = 4; run_to_end();
    chk("R8 wrap up phase", int'(phase), 4);
    chk("R8 wrap up count", int'(count), 8);
    target = 62; run_to_end();
    chk("R8 wrap down phase", int'(phase), 62);
    chk("R8 wrap down count", int'(count), 6);

    // R7 budget exhausted
    mode = 1; run_to_end();
    chk("R7 fail", int'(fail), 1);
    chk("R7 done low", int'(done), 0);
    chk("R7 bus stays closed", int'(bus_en), 0);
    chk("R7 count", int'(count), MAXA);
    chk("R7 phase", int'(phase), 22);
    repeat (10) @(negedge clk);
    chk("R7 phase frozen", int'(phase), 22);
    chk("R10 hw stays off", int'(hw), 0);
    chk("R10 sw stays on", int'(sw), 1);

    // changing status pattern, model comparison each cycle
    mode = 2; run_to_end();
    chk("R6/R7 pattern run ended", int'(done || fail), 1);
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule